// File: doc/BRIEF.md
# Manchester Receive Decoder for a 10 Mb/s Media-Independent Interface

This block turns a Manchester-coded line, sampled once per half-bit, into the receive half of an MII. A sample strobe marks each half-bit sample (nominally 20 MHz, twice the bit rate) and runs on a faster system clock. A signal-detect qualifier gates the strobe, so samples taken while the line is not qualified have no effect. The decoder searches for a preamble, locks to the bit boundary, waits for the two consecutive ones that close the preamble, and then packs the decoded bits into nibbles. Each nibble is presented on a 2.5 MHz receive clock.

A frame ends in one of two ways. The normal way is the idle terminator, which is two bit periods of line-high followed by two of line-low and occupies the nibble slot after the last data nibble. The other way is an unbroken run of zero half-bits, which cuts the frame off at once. Equal half-bit pairs inside a frame are coding violations and are reported with the nibble that contains them. The terminator's own equal pairs are not reported as violations.

Top module: `manch_rx_dec`

## Requirements
- R1: After reset, rxd, rx_dv, rx_er and rx_clk are all 0.
- R2: A data bit is coded as two half-bits, the inverse of the bit first and the bit itself second (1 = low then high). Decoded bits fill rxd least significant bit first, and the first bit after the closing 11 is bit 0 of the first nibble.
- R3: rx_dv stays low until at least four alternating preamble bits ending in 0 (half-bits 0,1,1,0,0,1,1,0) have been seen and are followed by two 1 bits. A frame whose preamble is shorter than that produces no nibble.
- R4: Lock does not depend on the first bits received or on the half-bit phase at which the stream starts. A preamble that starts with a 0 bit or after any number of idle half-bits still locks on the bit boundary.
- R5: rx_clk is high for 4 and low for 4 accepted samples. rxd changes only with a rising rx_clk, rx_dv rises with a rising rx_clk, and inside a frame nibbles are 8 accepted samples apart.
- R6: An equal half-bit pair inside a frame sets rx_er for exactly the nibble that contains it, the decoded bit being the pair's second half. rx_dv stays high.
- R7: When the nibble slot after the last data nibble carries half-bits 1,1,1,1,0,0,0,0, rx_dv falls on the sample that completes that slot, and no further nibble is delivered.
- R8: ZERO_RUN (default 6) consecutive zero half-bits inside a frame drop rx_dv on the last of them, even in the middle of a nibble. A shorter run does not.
- R9: Strobes that arrive while sig_det is low are ignored. Outputs and decoder state stay as they were, and the frame continues when sig_det returns.
- R10: rx_er is never high while rx_dv is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the sample strobe |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle pulse for each half-bit sample |
| smp_val | input | 1 | Line value of the current half-bit sample |
| sig_det | input | 1 | Line qualified; strobes are ignored while low |
| rxd | output | NIB_W | Received nibble, valid while rx_dv is high |
| rx_dv | output | 1 | Frame data valid |
| rx_er | output | 1 | Coding violation in the current nibble |
| rx_clk | output | 1 | Nibble clock, one period per 8 accepted samples |

## Verification
Two decisions can land on the same strobe: a nibble's last bit can carry a violation that has to be merged into the nibble presented on that strobe, and the nibble slot that closes on that strobe may turn out to be the terminator, whose two 11 pairs look like violations. The directed violation frame puts the bad pair on the last bit of a nibble, and the random frames place 00 or 11 pairs at random bits. The bench expects rx_er only on the nibble that holds the pair. Every frame also ends on the terminator, and the bench expects rx_dv to fall on its eighth half-bit with no rx_er and no extra nibble.

// File: rtl/manch_rx_pkg.sv
// Shared types for the Manchester receive decoder.
package manch_rx_pkg;

    // Frame controller phases: searching, locked in preamble, delivering data.
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } rx_state_t;

endpackage

// File: rtl/manch_rx_window.sv
// Half-bit history window.
// Keeps the most recent accepted half-bit samples and a saturating count of
// consecutive zeros. It flags three events for the sample being accepted now:
// the lock pattern (alternating preamble bits that end in 0), the idle
// terminator (first half of the window ones, second half zeros) and a zero run.
// Assumes stb is already qualified by signal detect.
module manch_rx_window #(
    parameter int WIN_W     = 8,
    parameter int LOCK_BITS = 4,
    parameter int ZERO_RUN  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic din,
    output logic lock_hit,
    output logic term_hit,
    output logic zrun_hit
);
    localparam int LOCK_W = 2 * LOCK_BITS;
    localparam int HIST_W = (WIN_W > LOCK_W) ? WIN_W : LOCK_W;
    localparam int ZC_W   = $clog2(ZERO_RUN + 1);
    localparam logic [ZC_W-1:0] ZC_LIM = ZC_W'(ZERO_RUN);

    // Lock pattern, oldest half-bit in the MSB: bits alternate and end in 0.
    function automatic logic [LOCK_W-1:0] lock_pattern();
        logic [LOCK_W-1:0] p;
        logic              b;
        for (int k = 0; k < LOCK_W; k++) begin
            b = ((LOCK_BITS - 1 - k / 2) % 2) == 1;
            p[LOCK_W-1-k] = (k % 2 == 0) ? ~b : b;
        end
        return p;
    endfunction

    // Terminator pattern: upper half ones, lower half zeros.
    function automatic logic [WIN_W-1:0] term_pattern();
        logic [WIN_W-1:0] p;
        for (int i = 0; i < WIN_W; i++) p[i] = (i >= WIN_W / 2);
        return p;
    endfunction

    localparam logic [LOCK_W-1:0] LOCK_PAT = lock_pattern();
    localparam logic [WIN_W-1:0]  TERM_PAT = term_pattern();

    logic [HIST_W-1:0] hist_q, hist_n;
    logic [ZC_W-1:0]   zc_q, zc_n;

    // Window including the sample offered now, and the next zero count.
    always_comb begin
        hist_n = {hist_q[HIST_W-2:0], din};
        if (din)                zc_n = '0;
        else if (zc_q == ZC_LIM) zc_n = zc_q;
        else                    zc_n = zc_q + 1'b1;
    end

    // Event flags for the sample offered now.
    always_comb begin
        lock_hit = stb && (hist_n[LOCK_W-1:0] == LOCK_PAT);
        term_hit = stb && (hist_n[WIN_W-1:0] == TERM_PAT);
        zrun_hit = stb && (zc_n == ZC_LIM);
    end

    // Advance the window and the zero count on accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            zc_q   <= '0;
        end else if (stb) begin
            hist_q <= hist_n;
            zc_q   <= zc_n;
        end
    end
endmodule

// File: rtl/manch_rx_frame.sv
// Frame controller and nibble assembler.
// Runs a half-bit phase counter, checks half-bit pairs, finds the closing 11
// of the preamble, packs bits LSB first and presents whole nibbles together
// with a nibble clock. A nibble slot is judged only when complete, so that
// the terminator's equal pairs never reach rx_er.
// Assumes 2*NIB_W samples per nibble and stb qualified by signal detect.
module manch_rx_frame
    import manch_rx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             din,
    input  logic             lock_hit,
    input  logic             term_hit,
    input  logic             zrun_hit,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             rx_clk
);
    localparam int PH_N = 2 * NIB_W;
    localparam int PH_W = $clog2(PH_N);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(NIB_W);

    rx_state_t        st_q, st_n;
    logic [PH_W-1:0]  ph_q, ph_n;
    logic             half_q, half_n;
    logic             last_q, last_n;
    logic [NIB_W-1:0] acc_q, acc_n, acc_full;
    logic             err_q, err_n;
    logic [NIB_W-1:0] rxd_q, rxd_n;
    logic             dv_q, dv_n;
    logic             er_q, er_n;
    logic             clk_q, clk_n;
    logic             pair_bad;

    // Next-state logic, evaluated once per accepted half-bit sample.
    always_comb begin
        st_n     = st_q;
        ph_n     = ph_q;
        half_n   = half_q;
        last_n   = last_q;
        acc_n    = acc_q;
        err_n    = err_q;
        rxd_n    = rxd_q;
        dv_n     = dv_q;
        er_n     = er_q;
        pair_bad = (half_q == din);
        acc_full = {din, acc_q[NIB_W-1:1]};
        if (stb) begin
            ph_n = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
            if (!ph_q[0]) half_n = din;
            case (st_q)
                ST_HUNT: begin
                    if (lock_hit) begin
                        st_n   = ST_PRE;
                        ph_n   = '0;
                        last_n = 1'b0;
                    end
                end
                ST_PRE: begin
                    if (ph_q[0]) begin
                        if (pair_bad) begin
                            st_n = ST_HUNT;
                        end else if (din && last_q) begin
                            st_n  = ST_DATA;
                            ph_n  = '0;
                            err_n = 1'b0;
                        end
                        last_n = din;
                    end
                end
                ST_DATA: begin
                    if (zrun_hit) begin
                        st_n = ST_HUNT;
                        dv_n = 1'b0;
                        er_n = 1'b0;
                    end else if (ph_q[0]) begin
                        acc_n = acc_full;
                        err_n = err_q | pair_bad;
                        if (ph_q == PH_LAST) begin
                            err_n = 1'b0;
                            if (term_hit) begin
                                st_n = ST_HUNT;
                                dv_n = 1'b0;
                                er_n = 1'b0;
                            end else begin
                                rxd_n = acc_full;
                                er_n  = err_q | pair_bad;
                                dv_n  = 1'b1;
                            end
                        end
                    end
                end
                default: st_n = ST_HUNT;
            endcase
        end
        clk_n = stb ? (ph_n < PH_HIGH) : clk_q;
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_HUNT;
            ph_q   <= '0;
            half_q <= 1'b0;
            last_q <= 1'b0;
            acc_q  <= '0;
            err_q  <= 1'b0;
            rxd_q  <= '0;
            dv_q   <= 1'b0;
            er_q   <= 1'b0;
            clk_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            ph_q   <= ph_n;
            half_q <= half_n;
            last_q <= last_n;
            acc_q  <= acc_n;
            err_q  <= err_n;
            rxd_q  <= rxd_n;
            dv_q   <= dv_n;
            er_q   <= er_n;
            clk_q  <= clk_n;
        end
    end

    assign rxd    = rxd_q;
    assign rx_dv  = dv_q;
    assign rx_er  = er_q;
    assign rx_clk = clk_q;
endmodule

// File: rtl/manch_rx_dec.sv
// Manchester receive decoder, top level.
// Qualifies the half-bit strobe with signal detect, feeds the history window
// and the frame controller, and drives the MII receive outputs.
// Assumes smp_stb is a one-cycle pulse per half-bit in the clk domain.
module manch_rx_dec #(
    parameter int NIB_W     = 4,
    parameter int LOCK_BITS = 4,
    parameter int ZERO_RUN  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_stb,
    input  logic             smp_val,
    input  logic             sig_det,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             rx_clk
);
    logic stb;
    logic lock_hit;
    logic term_hit;
    logic zrun_hit;

    // Only qualified samples advance the decoder.
    assign stb = smp_stb & sig_det;

    manch_rx_window #(
        .WIN_W    (2 * NIB_W),
        .LOCK_BITS(LOCK_BITS),
        .ZERO_RUN (ZERO_RUN)
    ) win_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .din     (smp_val),
        .lock_hit(lock_hit),
        .term_hit(term_hit),
        .zrun_hit(zrun_hit)
    );

    manch_rx_frame #(
        .NIB_W(NIB_W)
    ) frm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .din     (smp_val),
        .lock_hit(lock_hit),
        .term_hit(term_hit),
        .zrun_hit(zrun_hit),
        .rxd     (rxd),
        .rx_dv   (rx_dv),
        .rx_er   (rx_er),
        .rx_clk  (rx_clk)
    );
endmodule

// File: rtl/manch_rx_dec_chk.sv
// Property checker for the Manchester receive decoder, bound to the top.
// Watches only the ports and keeps its own zero-run counter.
module manch_rx_dec_chk #(
    parameter int NIB_W    = 4,
    parameter int ZERO_RUN = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_stb,
    input logic             smp_val,
    input logic             sig_det,
    input logic [NIB_W-1:0] rxd,
    input logic             rx_dv,
    input logic             rx_er,
    input logic             rx_clk
);
    localparam int ZC_W = $clog2(ZERO_RUN + 1);
    localparam logic [ZC_W-1:0] ZC_PRE = ZC_W'(ZERO_RUN - 1);

    logic            acc;
    logic [ZC_W-1:0] zc;

    assign acc = smp_stb && sig_det;

    // Count consecutive accepted zero samples, saturating at ZERO_RUN-1.
    always_ff @(posedge clk) begin
        if (!rst_n)              zc <= '0;
        else if (acc && smp_val) zc <= '0;
        else if (acc && zc != ZC_PRE) zc <= zc + 1'b1;
    end

    AST_ER_NEEDS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_dv); // R10

    AST_HOLD_WITHOUT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable({rxd, rx_dv, rx_er, rx_clk})); // R9

    AST_DV_RISE_ON_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> $rose(rx_clk)); // R5

    AST_RXD_ON_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && !$stable(rxd)) |-> $rose(rx_clk)); // R5

    AST_ZERO_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !smp_val && zc == ZC_PRE) |=> !rx_dv); // R8

    AST_DV_FALL_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dv) |-> $past(acc)); // R7
endmodule

bind manch_rx_dec manch_rx_dec_chk #(
    .NIB_W   (NIB_W),
    .ZERO_RUN(ZERO_RUN)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_stb(smp_stb),
    .smp_val(smp_val),
    .sig_det(sig_det),
    .rxd    (rxd),
    .rx_dv  (rx_dv),
    .rx_er  (rx_er),
    .rx_clk (rx_clk)
);

// File: tb/manch_rx_dec_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner frames plus seeded random frames.
module manch_rx_dec_tb_top;
    localparam int STB_DIV = 10;
    localparam int ZR      = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_stb = 1'b0;
    logic       smp_val = 1'b0;
    logic       sig_det = 1'b1;
    logic [3:0] rxd;
    logic       rx_dv, rx_er, rx_clk;

    always #2.5 clk = ~clk;

    manch_rx_dec #(.NIB_W(4), .LOCK_BITS(4), .ZERO_RUN(ZR)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_val(smp_val),
        .sig_det(sig_det), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .rx_clk(rx_clk)
    );

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    logic [3:0] exp_nib [0:31];
    logic       exp_er  [0:31];
    int         exp_cnt = 0;
    int         rcv_idx = 0;
    bit         dv_seen = 1'b0;
    bit         gap_flag = 1'b0;
    bit         have_last = 1'b0;
    longint     cyc = 0;
    longint     last_cyc = 0;
    logic       clk_prev = 1'b0;
    logic [3:0] rxd_prev = '0;
    bit         rose;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Monitor: compares delivered nibbles with the expected list.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            rose = rx_clk && !clk_prev;
            if (rx_er && !rx_dv) chk(1'b0, "R10 rx_er while rx_dv low", 1, 0);
            if (rxd !== rxd_prev && !rose) chk(1'b0, "R5 rxd moved off rising rx_clk", rxd, rxd_prev);
            if (rx_dv) dv_seen = 1'b1;
            if (rose && rx_dv) begin
                if (rcv_idx < exp_cnt) begin
                    chk(rxd == exp_nib[rcv_idx], "R2 nibble value", rxd, exp_nib[rcv_idx]);
                    chk(rx_er == exp_er[rcv_idx], "R6 rx_er per nibble", rx_er, exp_er[rcv_idx]);
                    if (have_last && !gap_flag)
                        chk(cyc - last_cyc == 8 * STB_DIV, "R5 nibble spacing",
                            int'(cyc - last_cyc), 8 * STB_DIV);
                end else begin
                    chk(1'b0, "R7 extra nibble", rcv_idx, exp_cnt);
                end
                rcv_idx++;
                have_last = 1'b1;
                last_cyc = cyc;
            end
        end
        clk_prev = rx_clk;
        rxd_prev = rxd;
    end

    // One half-bit sample: strobe for one cycle, STB_DIV cycles per sample.
    task automatic send_half(input logic v);
        @(negedge clk);
        smp_val = v;
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        repeat (STB_DIV - 2) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        send_half(~b);
        send_half(b);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_half(1'b0);
    endtask

    // Full frame: idle, preamble ending 0, closing 11, data, then terminator
    // or a zero run. vn<0 means no violation.
    task automatic run_frame(input int nnib, input int npre, input int vn, input int vb,
                             input logic vv, input bit drop, input bit abort);
        logic [3:0] snap_rxd;
        logic       snap_dv, snap_er, snap_clk;
        for (int k = 0; k < nnib; k++) begin
            exp_nib[k] = 4'($urandom);
            exp_er[k]  = 1'b0;
        end
        if (vn >= 0) begin
            exp_nib[vn][vb] = vv;
            exp_er[vn] = 1'b1;
        end
        exp_cnt = nnib; rcv_idx = 0; have_last = 1'b0; dv_seen = 1'b0; gap_flag = drop;
        send_idle(1 + int'($urandom % 7));
        for (int i = 0; i < npre; i++) send_bit(((npre - 1 - i) % 2) == 1);
        send_bit(1'b1);
        send_bit(1'b1);
        for (int k = 0; k < nnib; k++) begin
            for (int j = 0; j < 4; j++) begin
                if (k == vn && j == vb) begin
                    send_half(vv);
                    send_half(vv);
                end else begin
                    send_bit(exp_nib[k][j]);
                end
                if (drop && k == 1 && j == 1) begin
                    snap_rxd = rxd; snap_dv = rx_dv; snap_er = rx_er; snap_clk = rx_clk;
                    sig_det = 1'b0;
                    for (int g = 0; g < 16; g++) send_half(1'($urandom));
                    chk({rxd, rx_dv, rx_er, rx_clk} == {snap_rxd, snap_dv, snap_er, snap_clk},
                        "R9 outputs held while sig_det low",
                        {rxd, rx_dv, rx_er, rx_clk}, {snap_rxd, snap_dv, snap_er, snap_clk});
                    sig_det = 1'b1;
                end
            end
        end
        if (abort) begin
            send_idle(ZR - 1);
            chk(rx_dv == 1'b1, "R8 rx_dv kept on short zero run", rx_dv, 1);
            send_half(1'b0);
            chk(rx_dv == 1'b0, "R8 rx_dv dropped on zero run", rx_dv, 0);
            chk(rx_er == 1'b0, "R10 rx_er low after abort", rx_er, 0);
        end else begin
            for (int i = 0; i < 8; i++) send_half(i < 4);
            chk(rx_dv == 1'b0, "R7 rx_dv dropped on terminator", rx_dv, 0);
            chk(rx_er == 1'b0, "R7 rx_er low on terminator", rx_er, 0);
        end
        chk(rcv_idx == exp_cnt, "R7 nibble count", rcv_idx, exp_cnt);
        send_idle(4);
        chk(rcv_idx == exp_cnt, "R7 nothing after frame end", rcv_idx, exp_cnt);
    endtask

    initial begin
        void'($urandom(32'h5EED_0A0B));
        repeat (4) @(negedge clk);
        chk({rxd, rx_dv, rx_er, rx_clk} == 7'd0, "R1 reset state", {rxd, rx_dv, rx_er, rx_clk}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({rxd, rx_dv, rx_er, rx_clk} == 7'd0, "R1 state after reset release",
            {rxd, rx_dv, rx_er, rx_clk}, 0);

        // R3: minimum preamble of four bits.
        run_frame(2, 4, -1, 0, 1'b0, 1'b0, 1'b0);
        // R4: preamble starting with a 0 bit.
        run_frame(3, 7, -1, 0, 1'b0, 1'b0, 1'b0);
        // R6: violation on the last bit of a nibble.
        run_frame(4, 8, 1, 3, 1'b0, 1'b0, 1'b0);
        run_frame(4, 8, 2, 3, 1'b1, 1'b0, 1'b0);
        // R9: signal detect drop in mid frame.
        run_frame(4, 10, -1, 0, 1'b0, 1'b1, 1'b0);
        // R8: zero-run abort after data.
        run_frame(2, 8, -1, 0, 1'b0, 1'b0, 1'b1);

        // R3: preamble too short, all-ones data, no lock expected.
        exp_cnt = 0; rcv_idx = 0; dv_seen = 1'b0; gap_flag = 1'b0;
        send_idle(3);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        for (int i = 0; i < 16; i++) send_bit(1'b1);
        for (int i = 0; i < 8; i++) send_half(i < 4);
        send_idle(4);
        chk(dv_seen == 1'b0, "R3 no rx_dv on short preamble", dv_seen, 0);
        chk(rcv_idx == 0, "R3 no nibble on short preamble", rcv_idx, 0);

        // Random frames.
        for (int f = 0; f < 14; f++) begin
            int nn;
            int vn;
            nn = 2 * (1 + int'($urandom % 6));
            vn = ($urandom % 2) ? int'($urandom % nn) : -1;
            run_frame(nn, 4 + int'($urandom % 12), vn, int'($urandom % 4),
                      1'($urandom), 1'b0, 1'b0);
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", rcv_idx, exp_cnt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule